// File: doc/BRIEF.md
# Debug Host Register Interface

This block is the register file that an external debug host reaches through a plain address/data access port with separate read and write strobes. It holds a control word (halt request, hart reset request, module-active flag and hart select), an abstract-command status word, a small bank of 32-bit data words and a small bank of program-buffer words. When the host reads the control word, the block computes the selected hart's state on the spot from per-hart halted flags and a per-hart presence input. It drives a halt request to the one selected hart, but only if that hart is present.

Writes to the command address are not stored. Instead, the block hands them to a separate command executor as a one-cycle pulse that carries the written word. The executor in turn supplies the busy flag and the command-error code, and both appear in the status read. Clearing the error is conditional, so the block sends the executor a one-cycle clear pulse when a clear is due. Writing the control word with the module-active flag at zero acts as a soft reset of the control and status state.

Top module: `dbg_host_regs`

## Requirements
- R1: After reset, `halt_req` is zero. A read of the control word (address 0x10) shows halt request (bit 31), reset request (bit 30), hart select (bits 23:16) and active (bit 0) all at zero. The same read shows version (bits 27:24) equal to 1, authenticated (bit 5) equal to 1, and auth type (bits 3:2) equal to 0, which means no authentication.
- R2: A control write with bit 0 set stores bit 31, bit 30 and the hart select from bits 23:16, and sets the active flag. All of these read back in the same positions.
- R3: `halt_req` has at most one bit set. Bit h is high only when the stored halt request is 1, the stored hart select equals h, and `hart_present[h]` is 1.
- R4: A control write with bit 0 clear stores none of its other fields. It clears the halt request, reset request, hart select, active flag and auto-execute bits, and it raises `cmderr_clr` for one cycle.
- R5: A control read reports hart status in bits 9:8. The codes are 2'b11 when the selected hart is not present, 2'b10 when it is present and halted, and 2'b01 when it is present and running. The status is sampled from the inputs in the cycle of the read strobe.
- R6: A read of the status word (address 0x16) returns auto-execute in bits 31:24, `exec_busy` in bit 12, `exec_cmderr` in bits 10:8, and the number of data words in bits 3:0.
- R7: A status write always stores bits 31:24 as the auto-execute bits. It raises `cmderr_clr` for one cycle only when bits 10:8 of the written word are zero; any other value produces no pulse.
- R8: Addresses from 0x04 up to 0x04 plus the data-word count reach the data bank, and addresses from 0x20 up to 0x20 plus the program size reach the program bank. In both windows a write stores the full word and a read returns it.
- R9: A read of the buffer-size word (address 0x17) returns the program-buffer word count in bits 23:16, with every other bit zero.
- R10: A write to the command address (0x18) gives `cmd_valid` high for exactly one cycle, starting in the cycle after the write strobe, with `cmd_data` equal to the written word. A read of 0x18 returns zero with no error.
- R11: A read of any address outside all mapped words, including the first address past each bank window, returns `acc_err` = 1 and zero data. A read of a mapped address returns `acc_err` = 0.
- R12: `acc_rdata` and `acc_err` are registered and become valid in the cycle after the read strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_addr | input | ADDR_W | Word address of the access |
| acc_rd | input | 1 | Read strobe |
| acc_wr | input | 1 | Write strobe |
| acc_wdata | input | 32 | Write data |
| acc_rdata | output | 32 | Read data, one cycle after the read strobe |
| acc_err | output | 1 | Error response for an unmapped read, valid with read data |
| hart_present | input | NUM_HARTS | Per-hart presence flags |
| hart_halted | input | NUM_HARTS | Per-hart halted flags |
| halt_req | output | NUM_HARTS | Halt request to the selected hart |
| exec_busy | input | 1 | Command executor busy |
| exec_cmderr | input | 3 | Command executor error code |
| cmd_valid | output | 1 | One-cycle command pulse |
| cmd_data | output | 32 | Command word sent with the pulse |
| cmderr_clr | output | 1 | One-cycle request to clear the executor's error |

## Verification
The bench builds the block with its default parameters: four harts, two data words and four program words. With these values the hart select can name a hart whose presence input is low, so the absent status code and the suppressed halt request can both be observed. The small banks keep the first address past each window close to mapped words, which is where the error boundary is checked. A status read with two data words and a live busy flag shows the count field and the executor inputs side by side.

// File: rtl/dbg_host_pkg.sv
// Package: shared field positions, constants and types for the debug host
// register interface. Assumes 32-bit register words.
package dbg_host_pkg;

    // Reported state of the selected hart
    typedef enum logic [1:0] {
        HS_RUNNING = 2'b01,
        HS_HALTED  = 2'b10,
        HS_ABSENT  = 2'b11
    } hart_stat_e;

    // Decoded target of an access, at most one bit set
    typedef struct packed {
        logic sel_data;
        logic sel_prog;
        logic sel_ctrl;
        logic sel_stat;
        logic sel_pbcfg;
        logic sel_cmd;
    } acc_sel_t;

    // Control word fields
    localparam int CTL_HALT_BIT   = 31;
    localparam int CTL_RST_BIT    = 30;
    localparam int CTL_VER_LSB    = 24;
    localparam int CTL_SEL_LSB    = 16;
    localparam int CTL_HSTAT_LSB  = 8;
    localparam int CTL_AUTH_BIT   = 5;
    localparam int CTL_ACTIVE_BIT = 0;
    localparam logic [3:0] CTL_VERSION = 4'd1;

    // Status word fields
    localparam int ST_AUTO_LSB = 24;
    localparam int ST_BUSY_BIT = 12;
    localparam int ST_ERR_LSB  = 8;
    localparam int ST_CNT_LSB  = 0;

    // Buffer-size word field
    localparam int PB_SIZE_LSB = 16;

endpackage

// File: rtl/dbg_addr_decode.sv
// Address decoder: maps a word address onto one register or bank window
// and gives the word index inside a bank. Assumes the windows do not overlap.
module dbg_addr_decode
    import dbg_host_pkg::*;
#(
    parameter int ADDR_W     = 7,
    parameter int DATA_BASE  = 4,
    parameter int DATA_WORDS = 2,
    parameter int PROG_BASE  = 32,
    parameter int PROG_WORDS = 4,
    parameter int CTRL_ADDR  = 16,
    parameter int STAT_ADDR  = 22,
    parameter int PBCFG_ADDR = 23,
    parameter int CMD_ADDR   = 24,
    localparam int DIDX_W    = (DATA_WORDS > 1) ? $clog2(DATA_WORDS) : 1,
    localparam int PIDX_W    = (PROG_WORDS > 1) ? $clog2(PROG_WORDS) : 1
) (
    input  logic [ADDR_W-1:0] addr,
    output acc_sel_t          sel,
    output logic [DIDX_W-1:0] data_idx,
    output logic [PIDX_W-1:0] prog_idx,
    output logic              miss
);

    logic [ADDR_W:0] a_ext;
    assign a_ext = {1'b0, addr};

    // Window and single-address compares
    always_comb begin
        sel = '0;
        sel.sel_data  = (a_ext >= (ADDR_W+1)'(DATA_BASE)) &&
                        (a_ext <  (ADDR_W+1)'(DATA_BASE + DATA_WORDS));
        sel.sel_prog  = (a_ext >= (ADDR_W+1)'(PROG_BASE)) &&
                        (a_ext <  (ADDR_W+1)'(PROG_BASE + PROG_WORDS));
        sel.sel_ctrl  = (addr == ADDR_W'(CTRL_ADDR));
        sel.sel_stat  = (addr == ADDR_W'(STAT_ADDR));
        sel.sel_pbcfg = (addr == ADDR_W'(PBCFG_ADDR));
        sel.sel_cmd   = (addr == ADDR_W'(CMD_ADDR));
    end

    // Word offset inside each bank
    assign data_idx = DIDX_W'(addr - ADDR_W'(DATA_BASE));
    assign prog_idx = PIDX_W'(addr - ADDR_W'(PROG_BASE));
    assign miss     = (sel == '0);

endmodule

// File: rtl/dbg_word_bank.sv
// Word bank: a small set of 32-bit words written and read by index.
// Assumes at most one write per cycle; an index past WORDS reads as zero.
module dbg_word_bank #(
    parameter int WORDS = 2,
    localparam int IDX_W = (WORDS > 1) ? $clog2(WORDS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] idx,
    input  logic [31:0]      wdata,
    output logic [31:0]      rdata
);

    logic [31:0] words [WORDS];

    // Store the addressed word on a write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < WORDS; i++) words[i] <= '0;
        end else if (wr_en) begin
            for (int i = 0; i < WORDS; i++)
                if (idx == IDX_W'(i)) words[i] <= wdata;
        end
    end

    // Read the addressed word
    always_comb begin
        rdata = '0;
        for (int i = 0; i < WORDS; i++)
            if (idx == IDX_W'(i)) rdata = words[i];
    end

endmodule

// File: rtl/dbg_ctrl_stat.sv
// Control and status state: halt/reset requests, hart select, active flag,
// auto-execute bits and the error-clear pulse. A control write with active
// clear acts as a soft reset. Assumes writes arrive one per cycle.
module dbg_ctrl_stat
    import dbg_host_pkg::*;
#(
    parameter int NUM_HARTS = 4,
    localparam int HART_W   = (NUM_HARTS > 1) ? $clog2(NUM_HARTS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_we,
    input  logic              stat_we,
    input  logic              wr_active,
    input  logic              wr_halt,
    input  logic              wr_rst,
    input  logic [HART_W-1:0] wr_sel,
    input  logic [7:0]        wr_auto,
    input  logic [2:0]        wr_err,
    input  logic [NUM_HARTS-1:0] hart_present,
    input  logic [NUM_HARTS-1:0] hart_halted,
    output logic              haltreq_q,
    output logic              rstreq_q,
    output logic              active_q,
    output logic [HART_W-1:0] hartsel_q,
    output logic [7:0]        autoexec_q,
    output logic              cmderr_clr,
    output hart_stat_e        hart_stat
);

    // Control, status and clear-pulse registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            haltreq_q  <= 1'b0;
            rstreq_q   <= 1'b0;
            active_q   <= 1'b0;
            hartsel_q  <= '0;
            autoexec_q <= '0;
            cmderr_clr <= 1'b0;
        end else begin
            cmderr_clr <= 1'b0;
            if (ctrl_we) begin
                if (wr_active) begin
                    haltreq_q <= wr_halt;
                    rstreq_q  <= wr_rst;
                    hartsel_q <= wr_sel;
                    active_q  <= 1'b1;
                end else begin
                    haltreq_q  <= 1'b0;
                    rstreq_q   <= 1'b0;
                    hartsel_q  <= '0;
                    active_q   <= 1'b0;
                    autoexec_q <= '0;
                    cmderr_clr <= 1'b1;
                end
            end else if (stat_we) begin
                autoexec_q <= wr_auto;
                cmderr_clr <= (wr_err == 3'd0);
            end
        end
    end

    // Live state of the selected hart
    always_comb begin
        if (!hart_present[hartsel_q])     hart_stat = HS_ABSENT;
        else if (hart_halted[hartsel_q])  hart_stat = HS_HALTED;
        else                              hart_stat = HS_RUNNING;
    end

endmodule

// File: rtl/dbg_host_regs.sv
// Debug host register interface top: decodes host accesses, holds the data
// and program banks and the control/status state, builds registered read
// data with an error flag, forwards command writes as a one-cycle pulse and
// drives the halt request to the selected, present hart.
// Assumes the host never asserts read and write in the same cycle.
module dbg_host_regs
    import dbg_host_pkg::*;
#(
    parameter int ADDR_W     = 7,
    parameter int NUM_HARTS  = 4,
    parameter int DATA_WORDS = 2,
    parameter int PROG_WORDS = 4,
    parameter int DATA_BASE  = 4,
    parameter int PROG_BASE  = 32,
    parameter int CTRL_ADDR  = 16,
    parameter int STAT_ADDR  = 22,
    parameter int PBCFG_ADDR = 23,
    parameter int CMD_ADDR   = 24
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    acc_addr,
    input  logic                 acc_rd,
    input  logic                 acc_wr,
    input  logic [31:0]          acc_wdata,
    output logic [31:0]          acc_rdata,
    output logic                 acc_err,
    input  logic [NUM_HARTS-1:0] hart_present,
    input  logic [NUM_HARTS-1:0] hart_halted,
    output logic [NUM_HARTS-1:0] halt_req,
    input  logic                 exec_busy,
    input  logic [2:0]           exec_cmderr,
    output logic                 cmd_valid,
    output logic [31:0]          cmd_data,
    output logic                 cmderr_clr
);

    localparam int HART_W = (NUM_HARTS > 1) ? $clog2(NUM_HARTS) : 1;
    localparam int DIDX_W = (DATA_WORDS > 1) ? $clog2(DATA_WORDS) : 1;
    localparam int PIDX_W = (PROG_WORDS > 1) ? $clog2(PROG_WORDS) : 1;

    acc_sel_t          sel;
    logic [DIDX_W-1:0] data_idx;
    logic [PIDX_W-1:0] prog_idx;
    logic              miss;
    logic [31:0]       data_rd, prog_rd, rdata_d;
    logic              haltreq_q, rstreq_q, active_q;
    logic [HART_W-1:0] hartsel_q;
    logic [7:0]        autoexec_q;
    hart_stat_e        hart_stat;

    dbg_addr_decode #(
        .ADDR_W(ADDR_W), .DATA_BASE(DATA_BASE), .DATA_WORDS(DATA_WORDS),
        .PROG_BASE(PROG_BASE), .PROG_WORDS(PROG_WORDS), .CTRL_ADDR(CTRL_ADDR),
        .STAT_ADDR(STAT_ADDR), .PBCFG_ADDR(PBCFG_ADDR), .CMD_ADDR(CMD_ADDR)
    ) u_dec (
        .addr(acc_addr), .sel(sel), .data_idx(data_idx),
        .prog_idx(prog_idx), .miss(miss)
    );

    dbg_word_bank #(.WORDS(DATA_WORDS)) u_data (
        .clk(clk), .rst_n(rst_n), .wr_en(acc_wr && sel.sel_data),
        .idx(data_idx), .wdata(acc_wdata), .rdata(data_rd)
    );

    dbg_word_bank #(.WORDS(PROG_WORDS)) u_prog (
        .clk(clk), .rst_n(rst_n), .wr_en(acc_wr && sel.sel_prog),
        .idx(prog_idx), .wdata(acc_wdata), .rdata(prog_rd)
    );

    dbg_ctrl_stat #(.NUM_HARTS(NUM_HARTS)) u_cs (
        .clk(clk), .rst_n(rst_n),
        .ctrl_we(acc_wr && sel.sel_ctrl),
        .stat_we(acc_wr && sel.sel_stat),
        .wr_active(acc_wdata[CTL_ACTIVE_BIT]),
        .wr_halt(acc_wdata[CTL_HALT_BIT]),
        .wr_rst(acc_wdata[CTL_RST_BIT]),
        .wr_sel(acc_wdata[CTL_SEL_LSB +: HART_W]),
        .wr_auto(acc_wdata[ST_AUTO_LSB +: 8]),
        .wr_err(acc_wdata[ST_ERR_LSB +: 3]),
        .hart_present(hart_present), .hart_halted(hart_halted),
        .haltreq_q(haltreq_q), .rstreq_q(rstreq_q), .active_q(active_q),
        .hartsel_q(hartsel_q), .autoexec_q(autoexec_q),
        .cmderr_clr(cmderr_clr), .hart_stat(hart_stat)
    );

    // Read data assembly for the decoded target
    always_comb begin
        rdata_d = '0;
        if (sel.sel_data) begin
            rdata_d = data_rd;
        end else if (sel.sel_prog) begin
            rdata_d = prog_rd;
        end else if (sel.sel_ctrl) begin
            rdata_d[CTL_HALT_BIT]              = haltreq_q;
            rdata_d[CTL_RST_BIT]               = rstreq_q;
            rdata_d[CTL_VER_LSB +: 4]          = CTL_VERSION;
            rdata_d[CTL_SEL_LSB +: HART_W]     = hartsel_q;
            rdata_d[CTL_HSTAT_LSB +: 2]        = hart_stat;
            rdata_d[CTL_AUTH_BIT]              = 1'b1;
            rdata_d[CTL_ACTIVE_BIT]            = active_q;
        end else if (sel.sel_stat) begin
            rdata_d[ST_AUTO_LSB +: 8]          = autoexec_q;
            rdata_d[ST_BUSY_BIT]               = exec_busy;
            rdata_d[ST_ERR_LSB +: 3]           = exec_cmderr;
            rdata_d[ST_CNT_LSB +: 4]           = 4'(DATA_WORDS);
        end else if (sel.sel_pbcfg) begin
            rdata_d[PB_SIZE_LSB +: 8]          = 8'(PROG_WORDS);
        end
    end

    // Registered read response
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_rdata <= '0;
            acc_err   <= 1'b0;
        end else begin
            acc_err <= acc_rd && miss;
            if (acc_rd) acc_rdata <= rdata_d;
        end
    end

    // Command forwarding pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_valid <= 1'b0;
            cmd_data  <= '0;
        end else begin
            cmd_valid <= acc_wr && sel.sel_cmd;
            if (acc_wr && sel.sel_cmd) cmd_data <= acc_wdata;
        end
    end

    // Per-hart halt request
    for (genvar h = 0; h < NUM_HARTS; h++) begin : g_halt
        assign halt_req[h] = haltreq_q && (hartsel_q == HART_W'(h)) && hart_present[h];
    end

endmodule

// File: rtl/dbg_host_regs_chk.sv
// Checker for dbg_host_regs: port-level timing and exclusivity properties.
// Assumes read and write strobes are never high together.
module dbg_host_regs_chk #(
    parameter int ADDR_W    = 7,
    parameter int NUM_HARTS = 4,
    parameter int CTRL_ADDR = 16,
    parameter int STAT_ADDR = 22,
    parameter int CMD_ADDR  = 24
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [ADDR_W-1:0]    acc_addr,
    input logic                 acc_rd,
    input logic                 acc_wr,
    input logic [31:0]          acc_wdata,
    input logic                 acc_err,
    input logic [NUM_HARTS-1:0] halt_req,
    input logic [NUM_HARTS-1:0] hart_present,
    input logic                 cmd_valid,
    input logic [31:0]          cmd_data,
    input logic                 cmderr_clr
);

    // R10
    cmd_pulse_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> $past(acc_wr && acc_addr == ADDR_W'(CMD_ADDR)));

    // R10
    cmd_data_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> cmd_data == $past(acc_wdata));

    // R12
    err_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_err |-> $past(acc_rd));

    // R3
    halt_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(halt_req));

    // R3
    halt_present_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (halt_req & ~hart_present) == '0);

    // R7
    clr_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmderr_clr |-> $past(acc_wr && (acc_addr == ADDR_W'(CTRL_ADDR) ||
                                        acc_addr == ADDR_W'(STAT_ADDR))));

endmodule

bind dbg_host_regs dbg_host_regs_chk #(
    .ADDR_W(ADDR_W), .NUM_HARTS(NUM_HARTS), .CTRL_ADDR(CTRL_ADDR),
    .STAT_ADDR(STAT_ADDR), .CMD_ADDR(CMD_ADDR)
) u_chk (
    .clk(clk), .rst_n(rst_n), .acc_addr(acc_addr), .acc_rd(acc_rd),
    .acc_wr(acc_wr), .acc_wdata(acc_wdata), .acc_err(acc_err),
    .halt_req(halt_req), .hart_present(hart_present), .cmd_valid(cmd_valid),
    .cmd_data(cmd_data), .cmderr_clr(cmderr_clr)
);

// File: tb/tb_dbg_host_regs.sv
// Bench for dbg_host_regs: a vector table walk for the banks and fixed words,
// then directed tests of control, status, command and soft reset.
module tb_dbg_host_regs;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [6:0]  acc_addr = '0;
    logic        acc_rd = 1'b0;
    logic        acc_wr = 1'b0;
    logic [31:0] acc_wdata = '0;
    logic [31:0] acc_rdata;
    logic        acc_err;
    logic [3:0]  hart_present = 4'b0111;
    logic [3:0]  hart_halted = 4'b0000;
    logic [3:0]  halt_req;
    logic        exec_busy = 1'b0;
    logic [2:0]  exec_cmderr = 3'd0;
    logic        cmd_valid;
    logic [31:0] cmd_data;
    logic        cmderr_clr;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    dbg_host_regs dut (
        .clk(clk), .rst_n(rst_n), .acc_addr(acc_addr), .acc_rd(acc_rd),
        .acc_wr(acc_wr), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
        .acc_err(acc_err), .hart_present(hart_present), .hart_halted(hart_halted),
        .halt_req(halt_req), .exec_busy(exec_busy), .exec_cmderr(exec_cmderr),
        .cmd_valid(cmd_valid), .cmd_data(cmd_data), .cmderr_clr(cmderr_clr)
    );

    // Table: {write, addr[6:0], data[31:0], expected err}; data is the written
    // word for writes and the expected read word for reads.
    localparam int NVEC = 15;
    localparam logic [40:0] VEC [NVEC] = '{
        {1'b1, 7'h04, 32'hAAAA5555, 1'b0},
        {1'b1, 7'h05, 32'h12345678, 1'b0},
        {1'b1, 7'h20, 32'h0BAD0001, 1'b0},
        {1'b1, 7'h23, 32'hCAFEF00D, 1'b0},
        {1'b0, 7'h04, 32'hAAAA5555, 1'b0},
        {1'b0, 7'h05, 32'h12345678, 1'b0},
        {1'b0, 7'h20, 32'h0BAD0001, 1'b0},
        {1'b0, 7'h21, 32'h00000000, 1'b0},
        {1'b0, 7'h23, 32'hCAFEF00D, 1'b0},
        {1'b0, 7'h17, 32'h00040000, 1'b0},
        {1'b0, 7'h18, 32'h00000000, 1'b0},
        {1'b0, 7'h06, 32'h00000000, 1'b1},
        {1'b0, 7'h24, 32'h00000000, 1'b1},
        {1'b0, 7'h03, 32'h00000000, 1'b1},
        {1'b0, 7'h7F, 32'h00000000, 1'b1}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    task automatic do_write(input logic [6:0] a, input logic [31:0] d);
        @(negedge clk);
        acc_addr = a; acc_wdata = d; acc_wr = 1'b1;
        @(negedge clk);
        acc_wr = 1'b0;
    endtask

    task automatic do_read(input logic [6:0] a, output logic [31:0] d, output logic e);
        @(negedge clk);
        acc_addr = a; acc_rd = 1'b1;
        @(negedge clk);
        acc_rd = 1'b0;
        d = acc_rdata; e = acc_err;
    endtask

    function automatic string tag_for(input logic [6:0] a, input logic e);
        if (e)          return "R11";
        if (a == 7'h17) return "R9";
        if (a == 7'h18) return "R10";
        return "R8";
    endfunction

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL R12 watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        logic        er;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state: hart 0 present and running
        check("R1 halt_req", 32'(halt_req), 32'h0);
        do_read(7'h10, rd, er);
        check("R1 ctrl", rd, 32'h0100_0120);
        check("R11 ctrl err", 32'(er), 32'h0);

        // R8 R9 R10 R11 table walk
        for (int i = 0; i < NVEC; i++) begin
            if (VEC[i][40]) begin
                do_write(VEC[i][39:33], VEC[i][32:1]);
            end else begin
                do_read(VEC[i][39:33], rd, er);
                check(tag_for(VEC[i][39:33], VEC[i][0]), rd, VEC[i][32:1]);
                check("R11 err", 32'(er), 32'(VEC[i][0]));
            end
        end

        // R2 R3 R5 select present halted hart 2 with halt request
        hart_halted = 4'b0100;
        do_write(7'h10, 32'h8002_0001);
        check("R3 halt_req hart2", 32'(halt_req), 32'h4);
        do_read(7'h10, rd, er);
        check("R2 R5 ctrl halted", rd, 32'h8102_0221);

        // R3 R5 absent hart 3: no request, status absent
        do_write(7'h10, 32'h8003_0001);
        check("R3 halt_req absent", 32'(halt_req), 32'h0);
        do_read(7'h10, rd, er);
        check("R5 ctrl absent", rd, 32'h8103_0321);

        // R2 R5 reset request captured, hart 1 running
        do_write(7'h10, 32'h4001_0001);
        check("R3 no halt", 32'(halt_req), 32'h0);
        do_read(7'h10, rd, er);
        check("R2 ctrl rst", rd, 32'h4101_0121);

        // R12 read data changes only after the read strobe's edge
        @(negedge clk);
        acc_addr = 7'h04; acc_rd = 1'b1;
        check("R12 before edge", acc_rdata, 32'h4101_0121);
        @(negedge clk);
        acc_rd = 1'b0;
        check("R12 after edge", acc_rdata, 32'hAAAA5555);

        // R6 status read with executor inputs
        exec_busy = 1'b1; exec_cmderr = 3'd5;
        do_read(7'h16, rd, er);
        check("R6 status", rd, 32'h0000_1502);

        // R7 nonzero error field: no clear, auto-exec stored
        do_write(7'h16, 32'hA500_0300);
        check("R7 no clear", 32'(cmderr_clr), 32'h0);
        do_read(7'h16, rd, er);
        check("R7 autoexec", rd, 32'hA500_1502);

        // R7 zero error field: one-cycle clear
        do_write(7'h16, 32'h5A00_0000);
        check("R7 clear pulse", 32'(cmderr_clr), 32'h1);
        @(negedge clk);
        check("R7 clear ends", 32'(cmderr_clr), 32'h0);

        // R10 command pulse and data
        do_write(7'h18, 32'hDEAD_BEEF);
        check("R10 cmd_valid", 32'(cmd_valid), 32'h1);
        check("R10 cmd_data", cmd_data, 32'hDEAD_BEEF);
        @(negedge clk);
        check("R10 cmd ends", 32'(cmd_valid), 32'h0);

        // R4 soft reset: select hart 2 halted, then deactivate with fields set
        do_write(7'h10, 32'h8002_0001);
        check("R3 halt_req set", 32'(halt_req), 32'h4);
        do_write(7'h10, 32'hC002_0000);
        check("R4 clear pulse", 32'(cmderr_clr), 32'h1);
        check("R4 halt_req", 32'(halt_req), 32'h0);
        do_read(7'h10, rd, er);
        check("R4 ctrl", rd, 32'h0100_0120);
        do_read(7'h16, rd, er);
        check("R4 autoexec", rd, 32'h0000_1502);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule